// File: doc/BRIEF.md
# Message padding unit for a 512-bit block hash

This unit sits in front of a 512-bit block compression engine of the MD5 family. It takes a message one byte at a time and cuts it into 64-byte blocks. It also appends the padding that the hash requires: a single marker bit, written as the byte 0x80, then zero fill, and finally the total message length in bits. Each block leaves on a 512-bit bus with a valid/ready handshake. A flag marks the block that ends the message.

The message ends on a beat that carries the last flag. A beat may also be marked as carrying no byte. This lets a message end without a trailing data byte, and it is the only way to send an empty message. The unit counts the bytes of the whole message. It then decides whether the length field fits after the marker in the current block, or whether one more block of pure padding must follow. While any block waits on the output, the input is held off.

Top module: `mdpad_unit`

## Requirements
- R1: Byte i of a block (0 to 63) is carried on out_block[8i+7:8i], and message bytes fill these positions in arrival order. Each time 64 message bytes have gathered before the end of the message, the block is presented with out_final=0.
- R2: The byte directly after the last message byte holds 0x80, and every byte between it and the length field (or the end of the block) is zero.
- R3: When the final group of message bytes is 55 bytes or fewer, the marker, the zeros and the length all go into that block. The length field is out_block[511:448] = 8 x total message bytes, least significant byte in byte 56, and out_final=1.
- R4: When the final group holds 56 to 63 bytes, that block ends with the marker and zeros and has out_final=0. It is followed by one block that is all zero except the length field, with out_final=1.
- R5: When the final group holds exactly 64 bytes, that block has out_final=0. It is followed by a block with 0x80 in byte 0, zeros, and the length field, with out_final=1.
- R6: A beat with in_void=1 adds no byte and never completes a block on its own. A void beat with in_last=1 ends the message, so an empty message yields exactly one block: 0x80 in byte 0, every other bit zero, out_final=1.
- R7: The length covers every byte of the message across all its blocks. It restarts from zero after the final block is handed over, and in_ready returns to 1 in the next cycle.
- R8: in_ready is 0 whenever out_valid is 1, including while an extra padding block is pending, and it is 1 otherwise.
- R9: While out_valid=1 and out_ready=0, out_block and out_final hold their values.
- R10: After reset, out_valid=0 and in_ready=1.
- R11: out_valid rises in the cycle after the beat that fills a block or ends the message is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_data | input | 8 | Message byte |
| in_valid | input | 1 | Input beat present |
| in_last | input | 1 | Beat ends the message |
| in_void | input | 1 | Beat carries no byte |
| in_ready | output | 1 | Unit accepts a beat |
| out_block | output | 512 | Block, byte i on bits 8i+7:8i |
| out_valid | output | 1 | Block present |
| out_final | output | 1 | Block is the last of the message |
| out_ready | input | 1 | Consumer takes the block |

## Verification
The bench aims at the lengths where the layout of the final block changes: 55 versus 56 bytes in the last group, and exactly 64 versus 65 bytes. An off-by-one in the fit test would either let the length field overwrite message bytes, or emit a spare block that is all padding. Mishandling a full last group would drop the marker, or put it in the wrong block. Empty and void-padded messages check that a beat without a byte neither advances the byte position nor adds to the length. Back-to-back messages with output stalls check that the length restarts, and that a held block does not change or let input in.

// File: rtl/mdpad_pkg.sv
package mdpad_pkg;
   typedef enum logic [0:0] {ST_FILL = 1'b0, ST_SEND = 1'b1} mdpad_st_e;
   localparam logic [7:0] MDPAD_MARK = 8'h80;
endpackage

// File: rtl/mdpad_len_acc.sv
module mdpad_len_acc #(
   parameter int LEN_BYTES = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   inc,
   input  logic                   clr,
   output logic [LEN_BYTES*8-1:0] len_cur,
   output logic [LEN_BYTES*8-1:0] len_nxt
);
   localparam int LEN_W = LEN_BYTES * 8;
   localparam int CNT_W = LEN_W - 3;

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_n;

   assign cnt_n = cnt_q + CNT_W'(inc);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt_q <= '0;
      else if (clr) cnt_q <= '0;
      else          cnt_q <= cnt_n;
   end

   // byte count times eight, wrapping at the field width
   assign len_cur = {cnt_q, 3'b000};
   assign len_nxt = {cnt_n, 3'b000};
endmodule

// File: rtl/mdpad_asm.sv
module mdpad_asm #(
   parameter int BLOCK_BYTES = 64,
   parameter int LEN_BYTES   = 8,
   parameter bit LEN_LE      = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       clr,
   input  logic                       wr_en,
   input  logic [$clog2(BLOCK_BYTES)-1:0] wr_pos,
   input  logic [7:0]                 wr_byte,
   input  logic                       mk_en,
   input  logic [$clog2(BLOCK_BYTES)-1:0] mk_pos,
   input  logic                       len_en,
   input  logic [LEN_BYTES*8-1:0]     len_bits,
   output logic [BLOCK_BYTES*8-1:0]   blk
);
   import mdpad_pkg::*;
   localparam int BLOCK_W = BLOCK_BYTES * 8;
   localparam int LEN_W   = LEN_BYTES * 8;

   logic [LEN_W-1:0]   len_field;
   logic [BLOCK_W-1:0] blk_q;
   logic [BLOCK_W-1:0] blk_n;

   generate
      if (LEN_LE) begin : g_len_le
         assign len_field = len_bits;
      end else begin : g_len_be
         for (genvar g = 0; g < LEN_BYTES; g++) begin : g_swap
            assign len_field[8*g +: 8] = len_bits[LEN_W-8-8*g +: 8];
         end
      end
   endgenerate

   always_comb begin
      blk_n = clr ? '0 : blk_q;
      if (wr_en)  blk_n[{wr_pos, 3'b000} +: 8] = wr_byte;
      if (mk_en)  blk_n[{mk_pos, 3'b000} +: 8] = MDPAD_MARK;
      if (len_en) blk_n[BLOCK_W-1 -: LEN_W]    = len_field;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) blk_q <= '0;
      else        blk_q <= blk_n;
   end

   assign blk = blk_q;
endmodule

// File: rtl/mdpad_unit.sv
module mdpad_unit #(
   parameter int BLOCK_BYTES = 64,
   parameter int LEN_BYTES   = 8,
   parameter bit LEN_LE      = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [7:0]               in_data,
   input  logic                     in_valid,
   input  logic                     in_last,
   input  logic                     in_void,
   output logic                     in_ready,
   output logic [BLOCK_BYTES*8-1:0] out_block,
   output logic                     out_valid,
   output logic                     out_final,
   input  logic                     out_ready
);
   import mdpad_pkg::*;
   localparam int POS_W   = $clog2(BLOCK_BYTES);
   localparam int CNT_W   = POS_W + 1;
   localparam int LEN_POS = BLOCK_BYTES - LEN_BYTES;
   localparam int LEN_W   = LEN_BYTES * 8;

   generate
      if (BLOCK_BYTES != (1 << POS_W)) begin : g_chk_pow2
         $error("BLOCK_BYTES must be a power of two");
      end
      if (LEN_BYTES < 1 || LEN_BYTES >= BLOCK_BYTES) begin : g_chk_len
         $error("LEN_BYTES must be between 1 and BLOCK_BYTES-1");
      end
   endgenerate

   mdpad_st_e        st_q;
   logic [CNT_W-1:0] cnt_q;
   logic             fin_q, pend_extra_q, pend_mark_q;

   logic             accept, has_byte, end_beat, fits, full;
   logic [CNT_W-1:0] w;
   logic [LEN_W-1:0] len_cur, len_nxt;
   logic             asm_clr, asm_mk, asm_len, len_clr, send_done;

   assign in_ready  = (st_q == ST_FILL);
   assign out_valid = (st_q == ST_SEND);
   assign out_final = fin_q;

   assign accept    = in_valid && in_ready;
   assign has_byte  = accept && !in_void;
   assign end_beat  = accept && in_last;
   assign w         = cnt_q + CNT_W'(has_byte);
   assign fits      = (w < CNT_W'(LEN_POS));
   assign full      = (w == CNT_W'(BLOCK_BYTES));
   assign send_done = out_valid && out_ready;

   assign asm_clr = send_done;
   assign asm_mk  = in_ready ? (end_beat && !full) : (send_done && pend_extra_q && pend_mark_q);
   assign asm_len = in_ready ? (end_beat && fits)  : (send_done && pend_extra_q);
   assign len_clr = send_done && !pend_extra_q && fin_q;

   mdpad_len_acc #(.LEN_BYTES(LEN_BYTES)) u_len (
      .clk(clk), .rst_n(rst_n), .inc(has_byte), .clr(len_clr),
      .len_cur(len_cur), .len_nxt(len_nxt)
   );

   mdpad_asm #(.BLOCK_BYTES(BLOCK_BYTES), .LEN_BYTES(LEN_BYTES), .LEN_LE(LEN_LE)) u_asm (
      .clk(clk), .rst_n(rst_n), .clr(asm_clr),
      .wr_en(has_byte), .wr_pos(cnt_q[POS_W-1:0]), .wr_byte(in_data),
      .mk_en(asm_mk), .mk_pos(in_ready ? w[POS_W-1:0] : '0),
      .len_en(asm_len), .len_bits(in_ready ? len_nxt : len_cur),
      .blk(out_block)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q         <= ST_FILL;
         cnt_q        <= '0;
         fin_q        <= 1'b0;
         pend_extra_q <= 1'b0;
         pend_mark_q  <= 1'b0;
      end else if (st_q == ST_FILL) begin
         if (end_beat) begin
            st_q         <= ST_SEND;
            cnt_q        <= '0;
            fin_q        <= fits;
            pend_extra_q <= !fits;
            pend_mark_q  <= full;
         end else if (full) begin
            st_q         <= ST_SEND;
            cnt_q        <= '0;
            fin_q        <= 1'b0;
            pend_extra_q <= 1'b0;
            pend_mark_q  <= 1'b0;
         end else begin
            cnt_q <= w;
         end
      end else if (out_ready) begin
         if (pend_extra_q) begin
            pend_extra_q <= 1'b0;
            fin_q        <= 1'b1;
         end else begin
            st_q  <= ST_FILL;
            fin_q <= 1'b0;
         end
      end
   end

   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_block) && $stable(out_final)));

   assert_end_to_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && in_last) |=> out_valid);

   assert_final_reopens_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready && out_final) |=> (in_ready && !out_valid));

   assert_void_no_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && in_void && !in_last) |=> !out_valid);
endmodule

// File: tb/mdpad_unit_tb.sv
module mdpad_unit_tb;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [7:0]   in_data = '0;
   logic         in_valid = 1'b0, in_last = 1'b0, in_void = 1'b0;
   logic         in_ready;
   logic [511:0] out_block;
   logic         out_valid, out_final;
   logic         out_ready = 1'b0;

   int checks = 0;
   int fails  = 0;

   always #5 clk = ~clk;

   mdpad_unit u_dut (
      .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
      .in_last(in_last), .in_void(in_void), .in_ready(in_ready),
      .out_block(out_block), .out_valid(out_valid), .out_final(out_final),
      .out_ready(out_ready)
   );

   localparam int NVEC = 14;
   localparam int LENS  [NVEC] = '{0, 1, 3, 55, 56, 60, 63, 64, 65, 119, 120, 127, 128, 130};
   localparam int STALLS[NVEC] = '{0, 1, 0, 2, 0, 1, 0, 3, 0, 0, 1, 0, 2, 0};

   task automatic chk(input bit ok, input string req, input string act, input string exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: got %s expected %s", req, act, exp);
      end
   endtask

   function automatic logic [7:0] mbyte(input int n, input int i);
      return 8'((i * 29 + n * 3 + 1) & 255);
   endfunction

   task automatic run_msg(input int n, input int stall, input int void_every);
      logic [7:0]   pb[$];
      logic [63:0]  bl;
      logic [511:0] eb;
      bit           efin, last_sent, r11_pend;
      int           nb, sent, ob, vc, rem;
      string        tag;
      pb = {};
      for (int i = 0; i < n; i++) pb.push_back(mbyte(n, i));
      pb.push_back(8'h80);                       // R2 marker
      while (pb.size() % 64 != 56) pb.push_back(8'h00);
      bl = 64'(n) * 64'd8;
      for (int j = 0; j < 8; j++) pb.push_back(bl[8*j +: 8]);
      nb = pb.size() / 64;
      rem = n % 64;
      sent = 0; ob = 0; vc = 0; last_sent = 0; r11_pend = 0;
      while (ob < nb) begin
         @(negedge clk);
         in_valid = 0; in_last = 0; in_void = 0; out_ready = 0;
         if (r11_pend) begin
            chk(out_valid, "R11", $sformatf("%0b", out_valid), "1");
            r11_pend = 0;
         end
         if (out_valid) begin
            for (int j = 0; j < 64; j++) eb[8*j +: 8] = pb[64*ob + j];
            efin = (ob == nb - 1);
            if (!efin)               tag = "R1";
            else if (n == 0)         tag = "R6";
            else if (rem == 0)       tag = "R5";
            else if (rem >= 56)      tag = "R4";
            else                     tag = "R3";
            chk(out_block == eb, tag, $sformatf("%h", out_block), $sformatf("%h", eb));
            chk(out_final == efin, tag, $sformatf("%0b", out_final), $sformatf("%0b", efin));
            chk(!in_ready, "R8", $sformatf("%0b", in_ready), "0");
            if (efin) chk(out_block[511:448] == bl, "R7",
                          $sformatf("%h", out_block[511:448]), $sformatf("%h", bl));
            for (int s = 0; s < stall; s++) begin
               @(negedge clk);
               chk(out_valid && out_block == eb && out_final == efin, "R9",
                   $sformatf("%0b/%h", out_valid, out_block), $sformatf("1/%h", eb));
               chk(!in_ready, "R8", $sformatf("%0b", in_ready), "0");
            end
            out_ready = 1;
            ob++;
         end else if (!last_sent) begin
            chk(in_ready, "R8", $sformatf("%0b", in_ready), "1");
            in_valid = 1;
            if (n == 0) begin
               in_void = 1; in_last = 1;              // R6 empty message
            end else if (void_every > 0 && (vc % void_every) == void_every - 1) begin
               in_void = 1;                           // R6 void beat mid-message
            end else begin
               in_data = mbyte(n, sent);
               in_last = (sent == n - 1);
               sent++;
            end
            vc++;
            if (in_last) begin
               last_sent = 1;
               r11_pend = 1;
            end
         end
      end
      @(negedge clk);
      in_valid = 0; in_last = 0; in_void = 0; out_ready = 0;
      chk(in_ready && !out_valid, "R7", $sformatf("%0b/%0b", in_ready, out_valid), "1/0");
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      chk(!out_valid, "R10", $sformatf("%0b", out_valid), "0");
      chk(in_ready,   "R10", $sformatf("%0b", in_ready), "1");

      // table walk: lengths around 55/56 and 64/65 boundaries, back to back (R7)
      for (int k = 0; k < NVEC; k++) run_msg(LENS[k], STALLS[k], 0);

      // directed: void beats inside messages (R6), crossing a block boundary
      run_msg(20, 1, 4);
      run_msg(70, 0, 3);
      run_msg(56, 0, 5);
      // directed: empty message after a long one, length restarts (R7)
      run_msg(200, 1, 0);
      run_msg(0, 2, 0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule